// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational arithmetic and logic unit for a small eight-bit processor core. Each evaluation takes two operands: a register value A and a memory or immediate value M. It also takes the four incoming condition flags (carry, zero, overflow, sign) and an operation code. From these it produces a result byte, the four updated flags and a strobe that says whether the result should be written back to a register.

Each operation follows its own flag rules. Subtraction treats the carry as an inverted borrow. Compare and bit test only touch flags and never write. Bit test takes sign and overflow directly from the operand. Any flag an operation does not define passes through unchanged. A decimal-mode flag input exists for interface compatibility, but the unit always does binary arithmetic.

Inside, a decoder turns the operation code into a packed set of strobes. A datapath uses those strobes to steer an adder, a logic unit, a shifter and an incrementer.

Top module: `alu8`

## Requirements
- R1: Operation code 0 (add with carry) gives result = (A + M + carry_i) mod 256 and sets carry_o when the unsigned sum exceeds 255.
- R2: Operation code 0 sets ovf_o exactly when the signed sum A + M + carry_i lies outside -128..127.
- R3: Operation code 1 (subtract with borrow) gives result = (A - M - (1 - carry_i)) mod 256 and sets carry_o when that unsigned difference is not negative.
- R4: Operation code 1 sets ovf_o exactly when the signed difference lies outside -128..127.
- R5: Operation code 2 (compare) sets carry_o when A >= M, and takes zero_o and sign_o from the 8-bit value A - M. It passes ovf_i through and holds writeEn_o low.
- R6: Operation code 3 (bit test) copies M bit 7 to sign_o and M bit 6 to ovf_o, and sets zero_o when (A AND M) is zero. It passes carry_i through and holds writeEn_o low.
- R7: Operation codes 4, 5 and 6 give A AND M, A OR M and A XOR M. They take zero_o and sign_o from the result and pass carry and overflow through.
- R8: Operation code 7 (shift left) moves A bit 7 to carry_o and fills bit 0 with 0. Operation code 8 (logical shift right) moves A bit 0 to carry_o, fills bit 7 with 0, and so always clears sign_o.
- R9: Operation code 9 (rotate left) moves carry_i into bit 0 and A bit 7 into carry_o. Operation code 10 (rotate right) moves carry_i into bit 7 and A bit 0 into carry_o. All shifts and rotates pass overflow through.
- R10: Operation codes 11 and 12 give (A + 1) mod 256 and (A - 1) mod 256. They update only zero_o and sign_o.
- R11: Operation code 13 (transfer) and the unused codes 14 and 15 pass A to the result and update only zero_o and sign_o.
- R12: decimal_i has no effect: outputs are the same binary results whatever its value.
- R13: writeEn_o is high for every operation code except 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel_i | input | 4 | Operation code (0..15) |
| opA_i | input | 8 | Register operand A |
| opM_i | input | 8 | Second operand M |
| carry_i | input | 1 | Incoming carry flag |
| zero_i | input | 1 | Incoming zero flag |
| ovf_i | input | 1 | Incoming overflow flag |
| sign_i | input | 1 | Incoming sign flag |
| decimal_i | input | 1 | Decimal-mode flag, ignored |
| result_o | output | 8 | Result byte |
| carry_o | output | 1 | Updated carry flag |
| zero_o | output | 1 | Updated zero flag |
| ovf_o | output | 1 | Updated overflow flag |
| sign_o | output | 1 | Updated sign flag |
| writeEn_o | output | 1 | Result should be written back |

## Verification
The adder is driven with operand pairs chosen to separate unsigned carry from signed overflow: a positive-plus-positive overflow with no carry, an all-ones wrap with carry and no overflow, and a case where both are set. Subtraction is run with carry both set and clear, which shows whether the borrow sense is inverted, and with mixed-sign operands that overflow. Compare and bit test are given incoming flags opposite to what they should preserve, so a unit that wrongly rewrites overflow or carry, or asserts the write strobe, shows up. Shifts and rotates use 0x80, 0x81 and 0x01 patterns with carry set, so fill bits and carry-out can be told apart. Decimal mode is set on an add whose decimal and binary answers differ.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,
    OP_SBC  = 4'd1,
    OP_CMP  = 4'd2,
    OP_BIT  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_ASL  = 4'd7,
    OP_LSR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_PASS = 4'd13
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_ADD   = 3'd0,
    UNIT_LOGIC = 3'd1,
    UNIT_SHIFT = 3'd2,
    UNIT_STEP  = 3'd3,
    UNIT_PASS  = 3'd4
  } aluUnit_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_XOR = 2'd2
  } logicFn_e;

  typedef struct packed {
    aluUnit_e unit;
    logic     invertM;
    logic     forceCarry;
    logicFn_e logicFn;
    logic     shiftRight;
    logic     rotate;
    logic     stepDown;
    logic     bitTest;
    logic     writeC;
    logic     writeV;
    logic     writeRes;
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] opSel_i,
  output aluCtrl_t   ctrl_o
);

  always_comb begin
    ctrl_o            = '0;
    ctrl_o.unit       = UNIT_PASS;
    ctrl_o.logicFn    = LOGIC_AND;
    ctrl_o.writeRes   = 1'b1;
    case (opSel_i)
      OP_ADC: begin
        ctrl_o.unit   = UNIT_ADD;
        ctrl_o.writeC = 1'b1;
        ctrl_o.writeV = 1'b1;
      end
      OP_SBC: begin
        ctrl_o.unit    = UNIT_ADD;
        ctrl_o.invertM = 1'b1;
        ctrl_o.writeC  = 1'b1;
        ctrl_o.writeV  = 1'b1;
      end
      OP_CMP: begin
        ctrl_o.unit       = UNIT_ADD;
        ctrl_o.invertM    = 1'b1;
        ctrl_o.forceCarry = 1'b1;
        ctrl_o.writeC     = 1'b1;
        ctrl_o.writeRes   = 1'b0;
      end
      OP_BIT: begin
        ctrl_o.unit     = UNIT_LOGIC;
        ctrl_o.logicFn  = LOGIC_AND;
        ctrl_o.bitTest  = 1'b1;
        ctrl_o.writeV   = 1'b1;
        ctrl_o.writeRes = 1'b0;
      end
      OP_AND: begin
        ctrl_o.unit    = UNIT_LOGIC;
        ctrl_o.logicFn = LOGIC_AND;
      end
      OP_OR: begin
        ctrl_o.unit    = UNIT_LOGIC;
        ctrl_o.logicFn = LOGIC_OR;
      end
      OP_XOR: begin
        ctrl_o.unit    = UNIT_LOGIC;
        ctrl_o.logicFn = LOGIC_XOR;
      end
      OP_ASL: begin
        ctrl_o.unit   = UNIT_SHIFT;
        ctrl_o.writeC = 1'b1;
      end
      OP_LSR: begin
        ctrl_o.unit       = UNIT_SHIFT;
        ctrl_o.shiftRight = 1'b1;
        ctrl_o.writeC     = 1'b1;
      end
      OP_ROL: begin
        ctrl_o.unit   = UNIT_SHIFT;
        ctrl_o.rotate = 1'b1;
        ctrl_o.writeC = 1'b1;
      end
      OP_ROR: begin
        ctrl_o.unit       = UNIT_SHIFT;
        ctrl_o.shiftRight = 1'b1;
        ctrl_o.rotate     = 1'b1;
        ctrl_o.writeC     = 1'b1;
      end
      OP_INC: begin
        ctrl_o.unit = UNIT_STEP;
      end
      OP_DEC: begin
        ctrl_o.unit     = UNIT_STEP;
        ctrl_o.stepDown = 1'b1;
      end
      default: begin
        ctrl_o.unit = UNIT_PASS;
      end
    endcase
  end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wideSum;

  always_comb begin
    wideSum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    sum_o   = wideSum[WIDTH-1:0];
    cout_o  = wideSum[WIDTH];
    // Signed overflow: like-signed inputs produce a sum of the other sign.
    ovf_o   = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluCtrl_t         ctrl_i,
  input  logic [WIDTH-1:0] opA_i,
  input  logic [WIDTH-1:0] opM_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             sign_o,
  output logic             writeEn_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addB;
  logic             addCin;
  logic [WIDTH-1:0] addSum;
  logic             addCout;
  logic             addOvf;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] shiftRes;
  logic             shiftCout;
  logic             shiftFill;
  logic [WIDTH-1:0] stepRes;
  logic             newCarry;
  logic             newOvf;

  assign addB   = ctrl_i.invertM ? ~opM_i : opM_i;
  assign addCin = ctrl_i.forceCarry ? 1'b1 : carry_i;

  alu8_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (opA_i),
    .b_i    (addB),
    .cin_i  (addCin),
    .sum_o  (addSum),
    .cout_o (addCout),
    .ovf_o  (addOvf)
  );

  always_comb begin
    case (ctrl_i.logicFn)
      LOGIC_OR:  logicRes = opA_i | opM_i;
      LOGIC_XOR: logicRes = opA_i ^ opM_i;
      default:   logicRes = opA_i & opM_i;
    endcase
  end

  always_comb begin
    shiftFill = ctrl_i.rotate ? carry_i : 1'b0;
    if (ctrl_i.shiftRight) begin
      shiftRes  = {shiftFill, opA_i[MSB:1]};
      shiftCout = opA_i[0];
    end else begin
      shiftRes  = {opA_i[MSB-1:0], shiftFill};
      shiftCout = opA_i[MSB];
    end
  end

  assign stepRes = ctrl_i.stepDown ? opA_i - {{(WIDTH-1){1'b0}}, 1'b1}
                                   : opA_i + {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    result_o = opA_i;
    newCarry = carry_i;
    newOvf   = addOvf;
    case (ctrl_i.unit)
      UNIT_ADD: begin
        result_o = addSum;
        newCarry = addCout;
      end
      UNIT_LOGIC: begin
        result_o = logicRes;
        newOvf   = opM_i[MSB-1];
      end
      UNIT_SHIFT: begin
        result_o = shiftRes;
        newCarry = shiftCout;
      end
      UNIT_STEP: result_o = stepRes;
      default:   result_o = opA_i;
    endcase
  end

  always_comb begin
    zero_o    = (result_o == '0);
    sign_o    = ctrl_i.bitTest ? opM_i[MSB] : result_o[MSB];
    carry_o   = ctrl_i.writeC ? newCarry : carry_i;
    ovf_o     = ctrl_i.writeV ? newOvf : ovf_i;
    writeEn_o = ctrl_i.writeRes;
  end

endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       opSel_i,
  input  logic [WIDTH-1:0] opA_i,
  input  logic [WIDTH-1:0] opM_i,
  input  logic             carry_i,
  input  logic             zero_i,
  input  logic             ovf_i,
  input  logic             sign_i,
  input  logic             decimal_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             sign_o,
  output logic             writeEn_o
);

  aluCtrl_t ctrl;

  // Every operation recomputes zero and sign; binary arithmetic only (R12).
  logic unusedIn;
  assign unusedIn = zero_i ^ sign_i ^ decimal_i;

  alu8_ctrl u_ctrl (
    .opSel_i (opSel_i),
    .ctrl_o  (ctrl)
  );

  alu8_datapath #(.WIDTH(WIDTH)) u_dp (
    .ctrl_i    (ctrl),
    .opA_i     (opA_i),
    .opM_i     (opM_i),
    .carry_i   (carry_i),
    .ovf_i     (ovf_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .zero_o    (zero_o),
    .ovf_o     (ovf_o),
    .sign_o    (sign_o),
    .writeEn_o (writeEn_o)
  );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [3:0]       opSel_i,
  input logic [WIDTH-1:0] opA_i,
  input logic [WIDTH-1:0] opM_i,
  input logic             carry_i,
  input logic             ovf_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             sign_o,
  input logic             writeEn_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] refSum;
  assign refSum = {1'b0, opA_i} + {1'b0, opM_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    if (!$isunknown({opSel_i, opA_i, opM_i, carry_i, ovf_i})) begin
      if (opSel_i == OP_ADC) begin
        // R1
        adc_sum_chk: assert ({carry_o, result_o} == refSum)
          else $error("adc sum/carry mismatch");
      end
      if (opSel_i == OP_CMP) begin
        // R5
        cmp_flags_chk: assert (carry_o == (opA_i >= opM_i) && ovf_o == ovf_i && !writeEn_o)
          else $error("compare flag rule broken");
      end
      if (opSel_i == OP_BIT) begin
        // R6
        bit_flags_chk: assert (sign_o == opM_i[MSB] && ovf_o == opM_i[MSB-1]
                               && carry_o == carry_i && zero_o == ((opA_i & opM_i) == '0))
          else $error("bit test flag rule broken");
      end
      if (opSel_i == OP_AND || opSel_i == OP_OR || opSel_i == OP_XOR) begin
        // R7
        logic_keeps_cv_chk: assert (carry_o == carry_i && ovf_o == ovf_i)
          else $error("logic op changed carry or overflow");
      end
      if (opSel_i == OP_LSR) begin
        // R8
        lsr_sign_clear_chk: assert (!sign_o && carry_o == opA_i[0])
          else $error("logical shift right flag rule broken");
      end
      // R13
      write_strobe_chk: assert (writeEn_o == !(opSel_i == OP_CMP || opSel_i == OP_BIT))
        else $error("write strobe wrong");
    end
  end

endmodule

bind alu8 alu8_chk #(.WIDTH(WIDTH)) u_chk (
  .opSel_i   (opSel_i),
  .opA_i     (opA_i),
  .opM_i     (opM_i),
  .carry_i   (carry_i),
  .ovf_i     (ovf_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .zero_o    (zero_o),
  .ovf_o     (ovf_o),
  .sign_o    (sign_o),
  .writeEn_o (writeEn_o)
);

// File: tb/alu8_bench.sv
`timescale 1ns/1ps
module alu8_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opSel = 4'd0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opM = 8'h00;
  logic       cIn = 1'b0;
  logic       zIn = 1'b0;
  logic       vIn = 1'b0;
  logic       nIn = 1'b0;
  logic       dIn = 1'b0;
  logic [7:0] res;
  logic       cOut;
  logic       zOut;
  logic       vOut;
  logic       nOut;
  logic       wrOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8 u_alu8 (
    .opSel_i   (opSel),
    .opA_i     (opA),
    .opM_i     (opM),
    .carry_i   (cIn),
    .zero_i    (zIn),
    .ovf_i     (vIn),
    .sign_i    (nIn),
    .decimal_i (dIn),
    .result_o  (res),
    .carry_o   (cOut),
    .zero_o    (zOut),
    .ovf_o     (vOut),
    .sign_o    (nOut),
    .writeEn_o (wrOut)
  );

  // Flags packed locally as {N,V,Z,C}. Result compared only when a write is expected.
  task automatic runCase(input string tag, input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] m, input logic [3:0] fin, input logic d,
                         input logic [7:0] expRes, input logic [3:0] expF, input logic expWr);
    logic [3:0] gotF;
    @(negedge clk);
    opSel = op; opA = a; opM = m; dIn = d;
    {nIn, vIn, zIn, cIn} = fin;
    #2;
    gotF = {nOut, vOut, zOut, cOut};
    checks++;
    if (gotF !== expF || wrOut !== expWr || (expWr && res !== expRes)) begin
      fails++;
      $display("FAIL %s: res=%h NVZC=%b wr=%b expected res=%h NVZC=%b wr=%b",
               tag, res, gotF, wrOut, expRes, expF, expWr);
    end
  endtask

  task automatic testIdle();
    runCase("R1 idle after reset", 4'd0, 8'h00, 8'h00, 4'b0000, 1'b0, 8'h00, 4'b0010, 1'b1);
  endtask

  task automatic testAdd();
    runCase("R2 pos overflow", 4'd0, 8'h50, 8'h50, 4'b0000, 1'b0, 8'hA0, 4'b1100, 1'b1);
    runCase("R1 wrap carry",   4'd0, 8'hFF, 8'h01, 4'b1100, 1'b0, 8'h00, 4'b0011, 1'b1);
    runCase("R1 carry in",     4'd0, 8'h10, 8'h20, 4'b0001, 1'b0, 8'h31, 4'b0000, 1'b1);
    runCase("R2 neg overflow", 4'd0, 8'h80, 8'h80, 4'b0000, 1'b0, 8'h00, 4'b0111, 1'b1);
  endtask

  task automatic testSub();
    runCase("R3 no borrow",    4'd1, 8'h50, 8'h30, 4'b0001, 1'b0, 8'h20, 4'b0001, 1'b1);
    runCase("R3 borrow in",    4'd1, 8'h50, 8'h30, 4'b0000, 1'b0, 8'h1F, 4'b0001, 1'b1);
    runCase("R3 underflow",    4'd1, 8'h00, 8'h01, 4'b0001, 1'b0, 8'hFF, 4'b1000, 1'b1);
    runCase("R4 neg overflow", 4'd1, 8'h80, 8'h01, 4'b0001, 1'b0, 8'h7F, 4'b0101, 1'b1);
    runCase("R4 mixed sign",   4'd1, 8'h50, 8'hB0, 4'b0001, 1'b0, 8'hA0, 4'b1100, 1'b1);
  endtask

  task automatic testCompare();
    runCase("R5 equal keeps V", 4'd2, 8'h40, 8'h40, 4'b0100, 1'b0, 8'h00, 4'b0111, 1'b0);
    runCase("R5 less",          4'd2, 8'h10, 8'h20, 4'b0001, 1'b0, 8'h00, 4'b1000, 1'b0);
    runCase("R5 greater",       4'd2, 8'h20, 8'h10, 4'b1100, 1'b0, 8'h00, 4'b0101, 1'b0);
  endtask

  task automatic testBit();
    runCase("R6 zero and copy", 4'd3, 8'h0F, 8'hC0, 4'b0001, 1'b0, 8'h00, 4'b1111, 1'b0);
    runCase("R6 nonzero",       4'd3, 8'h01, 8'h41, 4'b1010, 1'b0, 8'h00, 4'b0100, 1'b0);
  endtask

  task automatic testLogic();
    runCase("R7 and",  4'd4, 8'hF0, 8'h3C, 4'b0101, 1'b0, 8'h30, 4'b0101, 1'b1);
    runCase("R7 or",   4'd5, 8'h80, 8'h01, 4'b0000, 1'b0, 8'h81, 4'b1000, 1'b1);
    runCase("R7 xor",  4'd6, 8'hAA, 8'hAA, 4'b1000, 1'b0, 8'h00, 4'b0010, 1'b1);
  endtask

  task automatic testShift();
    runCase("R8 asl",         4'd7, 8'h81, 8'h00, 4'b0100, 1'b0, 8'h02, 4'b0101, 1'b1);
    runCase("R8 lsr",         4'd8, 8'h81, 8'h00, 4'b1000, 1'b0, 8'h40, 4'b0001, 1'b1);
    runCase("R8 lsr ones",    4'd8, 8'hFF, 8'h00, 4'b0001, 1'b0, 8'h7F, 4'b0001, 1'b1);
    runCase("R9 rol",         4'd9, 8'h80, 8'h00, 4'b0001, 1'b0, 8'h01, 4'b0001, 1'b1);
    runCase("R9 ror carry",   4'd10, 8'h01, 8'h00, 4'b0101, 1'b0, 8'h80, 4'b1101, 1'b1);
    runCase("R9 ror no carry",4'd10, 8'h02, 8'h00, 4'b0000, 1'b0, 8'h01, 4'b0000, 1'b1);
  endtask

  task automatic testStepPass();
    runCase("R10 inc wrap",  4'd11, 8'hFF, 8'h00, 4'b0101, 1'b0, 8'h00, 4'b0111, 1'b1);
    runCase("R10 dec wrap",  4'd12, 8'h00, 8'h00, 4'b0010, 1'b0, 8'hFF, 4'b1000, 1'b1);
    runCase("R11 pass zero", 4'd13, 8'h00, 8'h55, 4'b1001, 1'b0, 8'h00, 4'b0011, 1'b1);
    runCase("R11 pass neg",  4'd13, 8'h90, 8'h00, 4'b0100, 1'b0, 8'h90, 4'b1100, 1'b1);
    runCase("R11 unused 15", 4'd15, 8'h12, 8'hFF, 4'b0000, 1'b0, 8'h12, 4'b0000, 1'b1);
  endtask

  task automatic testDecimal();
    runCase("R12 decimal ignored add", 4'd0, 8'h09, 8'h01, 4'b0000, 1'b1, 8'h0A, 4'b0000, 1'b1);
    runCase("R12 decimal ignored sub", 4'd1, 8'h10, 8'h01, 4'b0001, 1'b1, 8'h0F, 4'b0001, 1'b1);
  endtask

  task automatic testWrite();
    runCase("R13 write on shift", 4'd7, 8'h01, 8'h00, 4'b0000, 1'b0, 8'h02, 4'b0000, 1'b1);
    runCase("R13 no write on cmp", 4'd2, 8'h05, 8'h05, 4'b0000, 1'b0, 8'h00, 4'b0011, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog: run did not finish, expected completion");
        end
      end
      begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        testIdle();
        testAdd();
        testSub();
        testCompare();
        testBit();
        testLogic();
        testShift();
        testStepPass();
        testDecimal();
        testWrite();
        done = 1'b1;
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule